// File: doc/BRIEF.md
# Serial Command and Display-RAM Write Front End

This block receives a three-wire synchronous serial stream for a display controller: an active-low select, a serial clock and a data line. All three are brought into the system clock domain, and the rising edges of the serial clock are detected there. Bits are packed least significant first into 8-bit words.

The first complete word after select falls decides what the rest of the transaction means:

- An address word sets a 5-bit address counter. Every later word is then presented on a single-cycle RAM write port, and the counter moves up by one after each word.
- A command word updates one of two command registers. Every later word in that transaction is dropped.

The counter runs through 0x1E and 0x1F, which have no storage behind them, and then wraps to 0x00. No write strobe is issued for those two slots. The RAM array, the scan logic and the clock source are outside this block.

The controller moves through four states:

| State | Meaning | Transitions |
|---|---|---|
| `ST_IDLE` | Select is high. | Goes to `ST_FIRST` when select goes low. |
| `ST_FIRST` | Waiting for the word that classifies the transaction. | Goes to `ST_DATA` on an address word, or to `ST_SKIP` on either command word. |
| `ST_DATA` | Each word received is written to the display RAM. | Returns to `ST_IDLE` when select rises. |
| `ST_SKIP` | Each word received is discarded. | Returns to `ST_IDLE` when select rises. |

Rising select returns every state to `ST_IDLE`.

Top module: `vfd_serial_frontend`

## Requirements
- R1: Data is sampled on each rising serial-clock edge while select is low. Eight bits form a word, and the first bit received becomes bit 0.
- R2: A first word with bits 7:6 = 00 loads bits 4:0 into the address counter and ignores bit 5. That word produces no write.
- R3: In an address transaction, each later word is driven on `wr_data` with `wr_addr` equal to the counter, and the counter then increments.
- R4: Words aimed at address 30 or 31 produce no `wr_en`. The counter still advances through both, wraps from 31 to 0, and writes resume at 0.
- R5: A first word with bit 7 = 1 sets the control fields: `duty` from bits 6:4, `disp_on` from bit 3 and `shift_code` from bits 2:0.
- R6: A first word with bits 7:6 = 01 sets `init_char` from bits 3:0. The code 15 is refused and `init_char` keeps its old value.
- R7: After a command first word, the remaining words of that transaction cause no write and leave all fields unchanged.
- R8: Under reset, `duty` = 0, `disp_on` = 0, `shift_code` = 0, `init_char` = 1 and `wr_en` = 0.
- R9: If select rises before a word has eight bits, those bits are discarded. The next transaction starts a new word and a new classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Transaction select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data |
| wr_en | output | 1 | Display RAM write strobe, one cycle |
| wr_addr | output | 5 | Display RAM write address |
| wr_data | output | 8 | Display RAM write data |
| duty | output | 3 | Duty-ratio code |
| disp_on | output | 1 | Display enable |
| shift_code | output | 3 | Shift-digit code |
| init_char | output | 4 | Initial character index |

## Verification
The assertions assume the serial inputs change slowly compared with `clk`. Each level of `sck`, and each value on `sdi`, is taken to last several system clocks, so that every serial edge appears exactly once after synchronisation. They also assume select only rises once the last complete word has been taken in. The stimulus meets these conditions by holding each serial level for four clocks and waiting several clocks after the last clock edge before raising select. The one deliberately cut-short word is the exception: there, select rises mid-word on purpose.

// File: rtl/vfd_ser_pkg.sv
package vfd_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_DATA,
        ST_SKIP
    } fe_state_e;

    typedef struct packed {
        logic [2:0] duty;
        logic       disp_on;
        logic [2:0] shift_code;
    } ctl1_t;

    localparam ctl1_t CTL1_RST = '{duty: 3'd0, disp_on: 1'b0, shift_code: 3'd0};

endpackage

// File: rtl/ser_input_sync.sv
module ser_input_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/ser_word_asm.sv
module ser_word_asm #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_lvl,
    input  logic              sdi_lvl,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    localparam int              CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic              sck_prev;
    logic              sck_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shnext;

    assign sck_rise = sck_lvl & ~sck_prev;
    assign shnext   = {sdi_lvl, shreg[WORD_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            sck_prev <= sck_lvl;
            word_vld <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg <= shnext;
                if (bit_cnt == LAST) begin
                    bit_cnt  <= '0;
                    word     <= shnext;
                    word_vld <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R9
    partial_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_cnt == '0));

    // R1
    word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> ($past(bit_cnt) == LAST));

endmodule

// File: rtl/ser_cmd_regs.sv
module ser_cmd_regs
    import vfd_ser_pkg::*;
#(
    parameter int          INIT_W   = 4,
    parameter int          INIT_MAX = 14,
    parameter int          INIT_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld1,
    input  logic              ld2,
    input  logic [6:0]        cmd,
    output ctl1_t             ctl1,
    output logic [INIT_W-1:0] init_char
);

    logic init_ok;
    assign init_ok = (cmd[INIT_W-1:0] <= INIT_W'(INIT_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl1      <= CTL1_RST;
            init_char <= INIT_W'(INIT_RST);
        end else begin
            if (ld1) ctl1 <= ctl1_t'(cmd);
            if (ld2 && init_ok) init_char <= cmd[INIT_W-1:0];
        end
    end

    // R7
    ctl1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld1 |=> $stable(ctl1));

    // R6
    init_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_char <= INIT_W'(INIT_MAX));

    // R8
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl1 == CTL1_RST && init_char == INIT_W'(INIT_RST)));

endmodule

// File: rtl/vfd_serial_frontend.sv
module vfd_serial_frontend
    import vfd_ser_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int RAM_DEPTH   = 30,
    parameter int SYNC_STAGES = 2,
    parameter int INIT_W      = 4,
    parameter int INIT_MAX    = 14,
    parameter int INIT_RST    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [2:0]        duty,
    output logic              disp_on,
    output logic [2:0]        shift_code,
    output logic [INIT_W-1:0] init_char
);

    localparam logic [ADDR_W-1:0] LAST_REAL = ADDR_W'(RAM_DEPTH - 1);

    logic [2:0]        sync_q;
    logic              cs_act;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    fe_state_e         st_q, st_d;
    logic              first_vld, data_vld;
    logic              is_addr, is_c1, is_c2;
    logic [ADDR_W-1:0] addr_q;
    ctl1_t             ctl1;

    ser_input_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sdi, sck, cs_n}),
        .dout (sync_q)
    );

    assign cs_act = ~sync_q[0];

    ser_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_act  (cs_act),
        .sck_lvl (sync_q[1]),
        .sdi_lvl (sync_q[2]),
        .word_vld(word_vld),
        .word    (word)
    );

    assign is_addr   = (word[7:6] == 2'b00);
    assign is_c1     = word[7];
    assign is_c2     = (word[7:6] == 2'b01);
    assign first_vld = word_vld && cs_act && (st_q == ST_FIRST);
    assign data_vld  = word_vld && cs_act && (st_q == ST_DATA);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cs_act) st_d = ST_FIRST;
            ST_FIRST: if (word_vld) st_d = is_addr ? ST_DATA : ST_SKIP;
            ST_DATA:  st_d = ST_DATA;
            ST_SKIP:  st_d = ST_SKIP;
        endcase
        if (!cs_act) st_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= data_vld && (addr_q <= LAST_REAL);
            if (data_vld) begin
                wr_addr <= addr_q;
                wr_data <= word;
                addr_q  <= addr_q + 1'b1;
            end else if (first_vld && is_addr) begin
                addr_q <= word[ADDR_W-1:0];
            end
        end
    end

    ser_cmd_regs #(
        .INIT_W  (INIT_W),
        .INIT_MAX(INIT_MAX),
        .INIT_RST(INIT_RST)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld1      (first_vld && is_c1),
        .ld2      (first_vld && is_c2),
        .cmd      (word[6:0]),
        .ctl1     (ctl1),
        .init_char(init_char)
    );

    assign duty       = ctl1.duty;
    assign disp_on    = ctl1.disp_on;
    assign shift_code = ctl1.shift_code;

    // R4
    no_ghost_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= LAST_REAL));

    // R7
    write_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(st_q) == ST_DATA));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |=> (addr_q == $past(addr_q) + 1'b1));

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_en && st_q == ST_IDLE));

endmodule

// File: tb/vfd_serial_frontend_tb.sv
module vfd_serial_frontend_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] duty;
    logic       disp_on;
    logic [2:0] shift_code;
    logic [3:0] init_char;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model
    int m_mode = 0;   // 0 awaiting first word, 1 data, 2 skip
    int m_addr = 0;
    int m_duty = 0, m_on = 0, m_shift = 0, m_init = 1;
    int exp_a[$];
    int exp_d[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vfd_serial_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .duty(duty), .disp_on(disp_on), .shift_code(shift_code),
        .init_char(init_char)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compared every clock: each write strobe against the model queue
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_a.size() == 0) begin
                chk(0, "R3/R4/R7 unexpected write addr", wr_addr, -1);
            end else begin
                int ea, ed;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                chk(wr_addr == ea, "R3 write address", wr_addr, ea);
                chk(wr_data == ed, "R1/R3 write data", wr_data, ed);
            end
        end
    end

    task automatic model_word(input logic [7:0] w);
        if (m_mode == 0) begin
            if (w[7]) begin
                m_duty = w[6:4]; m_on = w[3]; m_shift = w[2:0]; m_mode = 2;
            end else if (w[6]) begin
                if (w[3:0] != 4'hF) m_init = w[3:0];
                m_mode = 2;
            end else begin
                m_addr = w[4:0]; m_mode = 1;
            end
        end else if (m_mode == 1) begin
            if (m_addr < 30) begin
                exp_a.push_back(m_addr);
                exp_d.push_back(w);
            end
            m_addr = (m_addr + 1) % 32;
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [7:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            sdi = w[i];
            sck = 1'b0;
            wait_clk(HOLD);
            sck = 1'b1;
            wait_clk(HOLD);
        end
        sck = 1'b0;
        wait_clk(HOLD);
    endtask

    task automatic send_word(input logic [7:0] w);
        model_word(w);
        send_bits(w, 8);
    endtask

    task automatic start_tx;
        m_mode = 0;
        cs_n = 1'b0;
        wait_clk(HOLD);
    endtask

    task automatic end_tx;
        wait_clk(6);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic check_regs(input string tag);
        chk(duty == m_duty[2:0], {tag, " duty"}, duty, m_duty);
        chk(disp_on == m_on[0], {tag, " disp_on"}, disp_on, m_on);
        chk(shift_code == m_shift[2:0], {tag, " shift_code"}, shift_code, m_shift);
        chk(init_char == m_init[3:0], {tag, " init_char"}, init_char, m_init);
        chk(exp_a.size() == 0, {tag, " pending writes"}, exp_a.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: state held in reset
        wait_clk(3);
        #2;
        chk(wr_en == 1'b0, "R8 wr_en in reset", wr_en, 0);
        check_regs("R8 reset");
        rst_n = 1'b1;
        wait_clk(4);

        // R2 and R3: bit 5 ignored, address 5, three data words
        start_tx;
        send_word(8'h25);
        send_word(8'hA1);
        send_word(8'hB2);
        send_word(8'hC3);
        end_tx;
        check_regs("R2/R3 address run");

        // R2: a lone address word writes nothing
        start_tx;
        send_word(8'h0A);
        end_tx;
        check_regs("R2 lone address");

        // R5 and R7: command 1 followed by stray words
        start_tx;
        send_word(8'hD9);
        send_word(8'h00);
        send_word(8'h41);
        end_tx;
        check_regs("R5/R7 command 1");

        // R6 and R7: command 2 followed by a stray word
        start_tx;
        send_word(8'h47);
        send_word(8'h0F);
        end_tx;
        check_regs("R6/R7 command 2");

        // R6: code 15 is refused
        start_tx;
        send_word(8'h4F);
        end_tx;
        chk(init_char == 4'd7, "R6 code 15 refused", init_char, 7);

        // R4: run past the top slots and wrap
        start_tx;
        send_word(8'h1C);
        for (int k = 0; k < 6; k++) send_word(8'h30 + 8'(k));
        end_tx;
        check_regs("R4 wrap");

        // R9: cut-short word then a fresh transaction
        start_tx;
        send_bits(8'hFF, 5);
        cs_n = 1'b1;
        wait_clk(8);
        check_regs("R9 partial no effect");
        start_tx;
        send_word(8'h03);
        send_word(8'h5A);
        end_tx;
        check_regs("R9 fresh transaction");

        // R5: all-zero command 1
        start_tx;
        send_word(8'h80);
        end_tx;
        check_regs("R5 command 1 zero");

        // R5: another pattern
        start_tx;
        send_word(8'hEE);
        end_tx;
        check_regs("R5 command 1 pattern");

        // R8: reset restores defaults
        rst_n = 1'b0;
        m_duty = 0; m_on = 0; m_shift = 0; m_init = 1;
        wait_clk(2);
        check_regs("R8 second reset");
        rst_n = 1'b1;
        wait_clk(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule